// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block holds the state number of a counter-based microcoded control unit and decides, every clock, which state comes next. The surrounding control logic reads a control word from its own memory at the address this block presents. The low two bits of that word, the address-control field, are fed back into this block. The other sixteen bits drive the datapath.

The address-control field picks one of four next-state sources:
- go back to state zero;
- step to the next state;
- look up the state in the first opcode-indexed dispatch table;
- look up the state in the second opcode-indexed dispatch table.

The first table fans out after instruction decode. The second table separates loads from stores after the address computation. Any opcode that a table does not recognise sends the control unit back to state zero.

Both tables are computed from the opcode constants, so no table contents are stored. A parameter selects how each table is built: either as a decode function of the opcode, or as a fully populated array indexed by the opcode. Both variants hold the same contents.

Top module: `useq_sequencer`

## Requirements
- R1: When `rst` is high at a rising edge, `state` becomes 0 after that edge, whatever `addr_ctl` and `op` are.
- R2: With `addr_ctl` = 0, `state` becomes 0 after the next rising edge.
- R3: With `addr_ctl` = 3, `state` becomes the current state plus one after the next rising edge, modulo 2^ST_W, so state 15 steps to 0 at the default width.
- R4: With `addr_ctl` = 1, `state` takes the first-table entry after the next rising edge. The entries are: opcode 0x00 (register format) gives 6, 0x23 (load) gives 2, 0x2B (store) gives 2, 0x04 (branch-if-equal) gives 8, and 0x02 (jump) gives 9.
- R5: With `addr_ctl` = 2, `state` takes the second-table entry after the next rising edge. The entries are: opcode 0x23 (load) gives 3, and 0x2B (store) gives 5.
- R6: An opcode that a table does not list yields state 0 from that table.
- R7: When `addr_ctl` is 0 or 3, the value on `op` has no effect on the next state.
- R8: The decode-function table variant (TBL_STYLE = 0) and the populated-array variant (TBL_STYLE = 1) produce identical state sequences for identical inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| op | input | OP_W (6) | Opcode used as the dispatch-table index |
| addr_ctl | input | 2 | Address-control field of the current control word |
| state | output | ST_W (4) | Current state, used as the control-memory address |

## Verification
The bench instantiates the block twice at the default widths, OP_W = 6 and ST_W = 4. One copy is built with TBL_STYLE = 0 and the other with TBL_STYLE = 1, so both table variants run on the same stimulus and are compared every cycle. With a 4-bit state, sixteen consecutive steps reach the wrap from 15 back to 0. With a 6-bit opcode, random stimulus covers all 64 table indices, including many undefined ones, in a few hundred cycles.

// File: rtl/useq_pkg.sv
package useq_pkg;

   // Address-control field encoding (low two bits of the control word)
   typedef enum logic [1:0] {
      ACTL_ZERO  = 2'd0,
      ACTL_TBL_A = 2'd1,
      ACTL_TBL_B = 2'd2,
      ACTL_STEP  = 2'd3
   } actl_e;

   // Opcode values recognised by the dispatch tables
   localparam int unsigned OPC_RFMT  = 'h00;
   localparam int unsigned OPC_JUMP  = 'h02;
   localparam int unsigned OPC_BEQ   = 'h04;
   localparam int unsigned OPC_LOAD  = 'h23;
   localparam int unsigned OPC_STORE = 'h2B;

   // Target states
   localparam int unsigned ST_MEMADR = 2;
   localparam int unsigned ST_LDRD   = 3;
   localparam int unsigned ST_STWR   = 5;
   localparam int unsigned ST_REXEC  = 6;
   localparam int unsigned ST_BRNCH  = 8;
   localparam int unsigned ST_JMP    = 9;
   localparam int unsigned ST_MAX    = 9;

endpackage

// File: rtl/useq_dispatch_tbl.sv
module useq_dispatch_tbl #(
   parameter int OP_W      = 6,
   parameter int ST_W      = 4,
   parameter bit SECOND    = 1'b0,
   parameter int TBL_STYLE = 0
) (
   input  logic [OP_W-1:0] op,
   output logic [ST_W-1:0] target
);
   import useq_pkg::*;

   localparam int DEPTH = 2 ** OP_W;

   if (OP_W < 6) begin : g_chk_op
      $error("useq_dispatch_tbl: OP_W must be at least 6");
   end
   if (TBL_STYLE != 0 && TBL_STYLE != 1) begin : g_chk_style
      $error("useq_dispatch_tbl: TBL_STYLE must be 0 or 1");
   end

   function automatic logic [ST_W-1:0] lookup(input logic [OP_W-1:0] o);
      logic [ST_W-1:0] r;
      r = '0;
      if (!SECOND) begin
         if (o == OP_W'(OPC_RFMT))       r = ST_W'(ST_REXEC);
         else if (o == OP_W'(OPC_LOAD))  r = ST_W'(ST_MEMADR);
         else if (o == OP_W'(OPC_STORE)) r = ST_W'(ST_MEMADR);
         else if (o == OP_W'(OPC_BEQ))   r = ST_W'(ST_BRNCH);
         else if (o == OP_W'(OPC_JUMP))  r = ST_W'(ST_JMP);
      end else begin
         if (o == OP_W'(OPC_LOAD))       r = ST_W'(ST_LDRD);
         else if (o == OP_W'(OPC_STORE)) r = ST_W'(ST_STWR);
      end
      return r;
   endfunction

   if (TBL_STYLE == 0) begin : g_decode
      always_comb target = lookup(op);
   end else begin : g_array
      logic [ST_W-1:0] rom [DEPTH];
      for (genvar i = 0; i < DEPTH; i++) begin : g_ent
         assign rom[i] = lookup(OP_W'(i));
      end
      assign target = rom[op];
   end

endmodule

// File: rtl/useq_next_sel.sv
module useq_next_sel #(
   parameter int ST_W = 4
) (
   input  useq_pkg::actl_e  ctl,
   input  logic [ST_W-1:0]  cur,
   input  logic [ST_W-1:0]  tbl_a,
   input  logic [ST_W-1:0]  tbl_b,
   output logic [ST_W-1:0]  nxt
);
   import useq_pkg::*;

   always_comb begin
      unique case (ctl)
         ACTL_ZERO:  nxt = '0;
         ACTL_TBL_A: nxt = tbl_a;
         ACTL_TBL_B: nxt = tbl_b;
         ACTL_STEP:  nxt = cur + ST_W'(1);
         default:    nxt = '0;
      endcase
   end

endmodule

// File: rtl/useq_state_reg.sv
module useq_state_reg #(
   parameter int ST_W = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [ST_W-1:0] d,
   output logic [ST_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
   end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer #(
   parameter int OP_W      = 6,
   parameter int ST_W      = 4,
   parameter int TBL_STYLE = 0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [OP_W-1:0] op,
   input  logic [1:0]      addr_ctl,
   output logic [ST_W-1:0] state
);
   import useq_pkg::*;

   if (ST_W < 4 || (2 ** ST_W) <= ST_MAX) begin : g_chk_st
      $error("useq_sequencer: ST_W too narrow for the state targets");
   end

   actl_e           ctl;
   logic [ST_W-1:0] tgt_a, tgt_b, nxt;

   assign ctl = actl_e'(addr_ctl);

   useq_dispatch_tbl #(.OP_W(OP_W), .ST_W(ST_W), .SECOND(1'b0), .TBL_STYLE(TBL_STYLE))
      u_tbl_a (.op(op), .target(tgt_a));

   useq_dispatch_tbl #(.OP_W(OP_W), .ST_W(ST_W), .SECOND(1'b1), .TBL_STYLE(TBL_STYLE))
      u_tbl_b (.op(op), .target(tgt_b));

   useq_next_sel #(.ST_W(ST_W)) u_sel (
      .ctl(ctl), .cur(state), .tbl_a(tgt_a), .tbl_b(tgt_b), .nxt(nxt)
   );

   useq_state_reg #(.ST_W(ST_W)) u_reg (
      .clk(clk), .rst(rst), .d(nxt), .q(state)
   );

   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> state == '0);

   a_r2_zero_select: assert property (@(posedge clk) disable iff (rst)
      addr_ctl == 2'd0 |=> state == '0);

   a_r3_step_wraps: assert property (@(posedge clk) disable iff (rst)
      addr_ctl == 2'd3 |=> state == $past(state) + ST_W'(1));

   a_r4_rfmt_exec: assert property (@(posedge clk) disable iff (rst)
      (addr_ctl == 2'd1 && op == OP_W'(OPC_RFMT)) |=> state == ST_W'(ST_REXEC));

   a_r5_load_read: assert property (@(posedge clk) disable iff (rst)
      (addr_ctl == 2'd2 && op == OP_W'(OPC_LOAD)) |=> state == ST_W'(ST_LDRD));

   a_r6_undef_b_zero: assert property (@(posedge clk) disable iff (rst)
      (addr_ctl == 2'd2 && op != OP_W'(OPC_LOAD) && op != OP_W'(OPC_STORE))
      |=> state == '0);

endmodule

// File: tb/sim_useq_sequencer.sv
`timescale 1ns/1ps
module sim_useq_sequencer;

   localparam int OP_W = 6;
   localparam int ST_W = 4;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [OP_W-1:0] op = '0;
   logic [1:0]      addr_ctl = 2'd0;
   logic [ST_W-1:0] state0, state1;

   int n_cmp = 0;
   int n_bad = 0;
   logic [ST_W-1:0] exp_st = '0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   useq_sequencer #(.OP_W(OP_W), .ST_W(ST_W), .TBL_STYLE(0)) u0 (
      .clk(clk), .rst(rst), .op(op), .addr_ctl(addr_ctl), .state(state0));

   useq_sequencer #(.OP_W(OP_W), .ST_W(ST_W), .TBL_STYLE(1)) u1 (
      .clk(clk), .rst(rst), .op(op), .addr_ctl(addr_ctl), .state(state1));

   function automatic logic [ST_W-1:0] tbl_a(input logic [OP_W-1:0] o);
      case (o)
         6'h00:        return 4'd6;
         6'h23, 6'h2B: return 4'd2;
         6'h04:        return 4'd8;
         6'h02:        return 4'd9;
         default:      return 4'd0;
      endcase
   endfunction

   function automatic logic [ST_W-1:0] tbl_b(input logic [OP_W-1:0] o);
      case (o)
         6'h23:   return 4'd3;
         6'h2B:   return 4'd5;
         default: return 4'd0;
      endcase
   endfunction

   function automatic logic [ST_W-1:0] model(input logic [ST_W-1:0] cur,
                                             input logic [1:0] c,
                                             input logic [OP_W-1:0] o);
      case (c)
         2'd0:    return 4'd0;
         2'd1:    return tbl_a(o);
         2'd2:    return tbl_b(o);
         default: return cur + 4'd1;
      endcase
   endfunction

   task automatic check(input string req, input logic [ST_W-1:0] got,
                        input logic [ST_W-1:0] want);
      n_cmp++;
      if (got !== want) begin
         n_bad++;
         $display("FAIL %s: state=%0d expected=%0d at %0t", req, got, want, $time);
      end
   endtask

   // Apply one cycle of stimulus, then compare after the edge
   task automatic cyc(input bit r, input logic [1:0] c, input logic [OP_W-1:0] o,
                      input string req);
      @(negedge clk);
      rst = r; addr_ctl = c; op = o;
      exp_st = r ? '0 : model(exp_st, c, o);
      @(posedge clk);
      #1;
      check(req, state0, exp_st);
      n_cmp++;
      if (state1 !== state0) begin
         n_bad++;
         $display("FAIL R8: array-variant state=%0d expected=%0d", state1, state0);
      end
   endtask

   initial begin
      cyc(1, 2'd3, 6'h00, "R1");
      cyc(1, 2'd1, 6'h2B, "R1");
      // load trace: 0 1 2 3 4 0
      cyc(0, 2'd3, 6'h23, "R3");
      cyc(0, 2'd1, 6'h23, "R4");
      cyc(0, 2'd2, 6'h23, "R5");
      cyc(0, 2'd3, 6'h23, "R3");
      cyc(0, 2'd0, 6'h23, "R2");
      // store trace: 0 1 2 5 0
      cyc(0, 2'd3, 6'h2B, "R3");
      cyc(0, 2'd1, 6'h2B, "R4");
      cyc(0, 2'd2, 6'h2B, "R5");
      cyc(0, 2'd0, 6'h2B, "R2");
      // register format: 0 1 6 7 0
      cyc(0, 2'd3, 6'h00, "R3");
      cyc(0, 2'd1, 6'h00, "R4");
      cyc(0, 2'd3, 6'h00, "R3");
      cyc(0, 2'd0, 6'h00, "R2");
      // branch and jump
      cyc(0, 2'd3, 6'h04, "R3");
      cyc(0, 2'd1, 6'h04, "R4");
      cyc(0, 2'd0, 6'h04, "R2");
      cyc(0, 2'd3, 6'h02, "R3");
      cyc(0, 2'd1, 6'h02, "R4");
      // undefined opcodes in both tables
      cyc(0, 2'd1, 6'h3F, "R6");
      cyc(0, 2'd3, 6'h11, "R3");
      cyc(0, 2'd2, 6'h00, "R6");
      cyc(0, 2'd3, 6'h04, "R3");
      cyc(0, 2'd2, 6'h02, "R6");
      // wrap 15 -> 0
      for (int i = 0; i < 17; i++) cyc(0, 2'd3, 6'(i * 5), "R3");
      // reset overrides a step mid-run
      cyc(0, 2'd3, 6'h00, "R3");
      cyc(1, 2'd3, 6'h00, "R1");
      // random mix
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 600; i++) begin
         logic [1:0] c;
         logic [OP_W-1:0] o;
         int pick;
         c = 2'($urandom_range(0, 3));
         pick = $urandom_range(0, 9);
         case (pick)
            0: o = 6'h00; 1: o = 6'h23; 2: o = 6'h2B; 3: o = 6'h04; 4: o = 6'h02;
            default: o = 6'($urandom);
         endcase
         if ($urandom_range(0, 49) == 0)
            cyc(1, c, o, "R1");
         else if (c == 2'd0 || c == 2'd3)
            cyc(0, c, o, "R7");
         else if (c == 2'd1)
            cyc(0, c, o, (tbl_a(o) == 0) ? "R6" : "R4");
         else
            cyc(0, c, o, (tbl_b(o) == 0) ? "R6" : "R5");
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (200000) @(posedge clk);
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
         end
      join_any
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule